// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the processor reset for a chip. It takes two inputs. The first is a digital "supply good" flag from an analog comparator, which arrives without timing relation to the system clock. The second is a single-cycle timeout request from a watchdog. While the supply is reported as low, reset stays asserted. When the supply comes back, reset is held for a fixed number of clock cycles. A watchdog request starts one reset pulse of that same length. One counter serves both cases.

The supply flag first passes a two-flop synchronizer. A duration filter follows it, so a low run shorter than a programmable number of cycles is discarded. A manual reset button that pulls the supply flag low is debounced for free. Each new accepted low phase reloads the hold counter, and every release starts the full hold period again.

The block drives an active-low reset and an active-high reset. It also drives a status flag that tells the watchdog that reset is in progress.

Top module: `supv_reset_gen`

## Requirements
- R1: While the filtered supply flag reports undervoltage, resetN stays 0, however long the low phase lasts.
- R2: After supplyOk returns to 1, resetN stays 0 for exactly RST_CYCLES+3 sampled cycles, counting from the first clock edge that sees the rise, and is then 1. The extra 3 cycles are 2 synchronizer cycles plus 1 filter-clear cycle.
- R3: An accepted undervoltage during the hold period reloads the hold counter, so the next release again gives RST_CYCLES+3 low cycles.
- R4: A low run on supplyOk shorter than GLITCH_CYCLES clock cycles is ignored, both in normal running and during a hold. A run of GLITCH_CYCLES cycles or more is accepted.
- R5: resetP is always the exact inverse of resetN, and resetActive always equals resetP.
- R6: A one-cycle wdogReq seen while reset is released asserts resetN at the next edge, for exactly RST_CYCLES cycles.
- R7: A wdogReq that arrives while reset is already asserted is ignored and does not extend the pulse.
- R8: The block's own synchronous reset rst forces resetN to 0. After rst is released with the supply good, resetN stays 0 for RST_CYCLES more cycles.
- R9: An accepted supply drop shows on resetN after GLITCH_CYCLES+3 edges, counting from the first edge that sees the low value. Over the whole event, resetN is low for L+RST_CYCLES-GLITCH_CYCLES+1 cycles, where L is the length of the low run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset of the block, active high |
| supplyOk | input | 1 | Supply-good comparator flag (1 = good), asynchronous |
| wdogReq | input | 1 | Watchdog timeout request, one clock cycle wide |
| resetN | output | 1 | Processor reset, active low |
| resetP | output | 1 | Processor reset, active high |
| resetActive | output | 1 | Status to the watchdog: reset is in progress |

## Verification
The watchdog pulse asserts reset one edge after the request. A supply drop reaches the outputs GLITCH_CYCLES+3 edges after it is first sampled. A supply rise releases reset RST_CYCLES+3 edges later. The bench drives its stimulus at falling clock edges and samples the outputs at the next falling edge. It numbers the samples from the first edge that sees the stimulus, so each expectation is a first-low index plus a count of low samples computed from these latencies. For each run it compares both numbers against the formula.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Controller state: undervoltage seen, hold timer running, reset released
  typedef enum logic [1:0] {
    ST_UNDER = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } supvState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic holdClr;
    logic holdInc;
  } holdStrobe_t;
endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int RST_CYCLES    = 64,
  parameter int GLITCH_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        supplyOk,
  input  holdStrobe_t strobe,
  output logic        uvFlag,
  output logic        holdDone
);
  localparam int LW = $clog2(GLITCH_CYCLES + 1);
  localparam int HW = $clog2(RST_CYCLES);
  localparam logic [LW-1:0] LOW_LIMIT = LW'(GLITCH_CYCLES);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_CYCLES - 1);

  // Synchronizer chain, reset to "good" so power-on timing rests on the hold
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   supSync;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= supplyOk;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], supplyOk};
      end
    end
  endgenerate

  assign supSync = syncQ[SYNC_STAGES-1];

  // Duration filter: counts consecutive low samples, saturating at the limit
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (rst)                     lowCnt <= '0;
    else if (supSync)            lowCnt <= '0;
    else if (lowCnt != LOW_LIMIT) lowCnt <= lowCnt + 1'b1;
  end

  assign uvFlag = (lowCnt == LOW_LIMIT);

  // Shared hold counter for brownout release and watchdog pulse
  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst)                 holdCnt <= '0;
    else if (strobe.holdClr) holdCnt <= '0;
    else if (strobe.holdInc) holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = (holdCnt == HOLD_LAST);

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    holdCnt <= HOLD_LAST);  // R6
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    lowCnt <= LOW_LIMIT);  // R4
  AST_GOOD_CLEARS_UV: assert property (@(posedge clk) disable iff (rst)
    supSync |=> !uvFlag);  // R4
  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    strobe.holdClr |=> (holdCnt == '0));  // R3
endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        uvFlag,
  input  logic        holdDone,
  input  logic        wdogReq,
  output holdStrobe_t strobe,
  output logic        resetActive
);
  supvState_e state, stNext;

  always_comb begin
    stNext = state;
    strobe = '0;
    unique case (state)
      ST_UNDER: begin
        strobe.holdClr = 1'b1;
        if (!uvFlag) stNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (uvFlag) begin
          stNext         = ST_UNDER;
          strobe.holdClr = 1'b1;
        end else if (holdDone) begin
          stNext = ST_RUN;
        end else begin
          strobe.holdInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (uvFlag) begin
          stNext         = ST_UNDER;
          strobe.holdClr = 1'b1;
        end else if (wdogReq) begin
          stNext         = ST_HOLD;
          strobe.holdClr = 1'b1;
        end
      end
      default: begin
        stNext         = ST_UNDER;
        strobe.holdClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_UNDER;
    else     state <= stNext;
  end

  assign resetActive = (state != ST_RUN);

  AST_UV_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    uvFlag |=> resetActive);  // R1
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!resetActive && wdogReq) |=> resetActive);  // R6
  AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(resetActive) |-> $past(holdDone));  // R2
  AST_WDOG_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && holdDone && !uvFlag && wdogReq) |=> !resetActive);  // R7
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int RST_CYCLES    = 64,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic supplyOk,
  input  logic wdogReq,
  output logic resetN,
  output logic resetP,
  output logic resetActive
);
  holdStrobe_t strobe;
  logic        uvFlag;
  logic        holdDone;
  logic        active;

  supv_datapath #(
    .RST_CYCLES   (RST_CYCLES),
    .GLITCH_CYCLES(GLITCH_CYCLES),
    .SYNC_STAGES  (2)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .supplyOk(supplyOk),
    .strobe  (strobe),
    .uvFlag  (uvFlag),
    .holdDone(holdDone)
  );

  supv_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .uvFlag     (uvFlag),
    .holdDone   (holdDone),
    .wdogReq    (wdogReq),
    .strobe     (strobe),
    .resetActive(active)
  );

  assign resetN      = ~active;
  assign resetP      = active;
  assign resetActive = active;

  AST_RST_FORCES: assert property (@(posedge clk)
    rst |=> !resetN);  // R8
endmodule

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;
  localparam int RC = 20;
  localparam int GC = 5;
  localparam int NV = 8;
  localparam logic KWD = 1'b0;
  localparam logic KSUP = 1'b1;
  // each entry: {kind, low-run length}
  localparam logic [16:0] VEC [NV] = '{
    {KWD, 16'd0}, {KSUP, 16'd1}, {KSUP, 16'd4}, {KSUP, 16'd5},
    {KSUP, 16'd6}, {KSUP, 16'd12}, {KSUP, 16'd40}, {KWD, 16'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supplyOk = 1'b1;
  logic wdogReq = 1'b0;
  logic resetN, resetP, resetActive;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  supv_reset_gen #(.RST_CYCLES(RC), .GLITCH_CYCLES(GC)) u0 (
    .clk(clk), .rst(rst), .supplyOk(supplyOk), .wdogReq(wdogReq),
    .resetN(resetN), .resetP(resetP), .resetActive(resetActive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // count low samples from a supply rise driven now, until release
  task automatic countRelease(input int glitchAt, output int lowCnt);
    lowCnt = 0;
    supplyOk = 1'b1;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (resetN) break;
      lowCnt++;
      if (glitchAt > 0) supplyOk = !(k >= glitchAt && k < glitchAt + GC - 3);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lowCnt, firstLow, expLow, expFirst, len;
    logic kind;
    repeat (3) @(negedge clk);
    check(!resetN && resetP && resetActive, "R8 reset state", resetN, 0);
    rst = 1'b0;
    lowCnt = 0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (resetN) break;
      lowCnt++;
    end
    check(lowCnt == RC, "R8 hold after rst", lowCnt, RC);

    // vector table
    for (int v = 0; v < NV; v++) begin
      kind = VEC[v][16];
      len = int'(VEC[v][15:0]);
      if (kind == KWD) begin
        expLow = RC; expFirst = 1;
      end else begin
        expLow = (len >= GC) ? len + RC - GC + 1 : 0;
        expFirst = (len >= GC) ? GC + 3 : 0;
      end
      lowCnt = 0; firstLow = 0;
      if (kind == KWD) wdogReq = 1'b1; else supplyOk = 1'b0;
      for (int k = 1; k <= len + RC + 16; k++) begin
        @(negedge clk);
        check(resetP == !resetN && resetActive == resetP, "R5 inverse", resetP, !resetN);
        if (!resetN) begin
          lowCnt++;
          if (firstLow == 0) firstLow = k;
        end
        wdogReq = 1'b0;
        if (kind == KSUP) supplyOk = (k >= len);
      end
      if (kind == KWD) begin
        check(lowCnt == expLow, "R6 wdog pulse length", lowCnt, expLow);
        check(firstLow == expFirst, "R6 wdog pulse start", firstLow, expFirst);
      end else if (len < GC) begin
        check(lowCnt == 0, "R4 glitch ignored", lowCnt, 0);
        check(firstLow == 0, "R4 glitch no start", firstLow, 0);
      end else begin
        check(lowCnt == expLow, "R9 low cycle count", lowCnt, expLow);
        check(firstLow == expFirst, "R9 first low index", firstLow, expFirst);
      end
    end

    // R1: long undervoltage keeps reset asserted; R2: release timing
    supplyOk = 1'b0;
    repeat (80) @(negedge clk);
    check(!resetN && resetActive, "R1 held while low", resetN, 0);
    countRelease(0, lowCnt);
    check(lowCnt == RC + 3, "R2 release hold", lowCnt, RC + 3);

    // R3: accepted drop during hold restarts the full hold
    supplyOk = 1'b0;
    repeat (15) @(negedge clk);
    supplyOk = 1'b1;
    repeat (8) @(negedge clk);
    check(!resetN, "R3 still in hold", resetN, 0);
    supplyOk = 1'b0;
    repeat (12) @(negedge clk);
    countRelease(0, lowCnt);
    check(lowCnt == RC + 3, "R3 reload hold", lowCnt, RC + 3);

    // R4: short glitch during hold does not extend it
    supplyOk = 1'b0;
    repeat (15) @(negedge clk);
    countRelease(6, lowCnt);
    check(lowCnt == RC + 3, "R4 glitch in hold", lowCnt, RC + 3);
    repeat (10) @(negedge clk);
    check(resetN == 1'b1, "R4 released after glitch", resetN, 1);

    // R7: second watchdog request during the pulse is ignored
    wdogReq = 1'b1;
    lowCnt = 0;
    for (int k = 1; k < RC + 20; k++) begin
      @(negedge clk);
      if (!resetN) lowCnt++;
      wdogReq = (k == RC - 2) || (k == RC - 1);
    end
    check(lowCnt == RC, "R7 no extension", lowCnt, RC);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule